// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit processor core: two external request pins, two timer overflow events and one serial request that covers both receive and transmit. Each source has an enable bit. A master enable can veto all of them. Each source can also be placed at a high or a low priority level.

Toward the core, the controller presents one request line and a 16-bit vector address for the winning source. The core asserts `ack` at an instruction boundary to take the request. The controller then records, inside itself, which level is in service. It also clears the request flag when that source has a self-clearing flag. A one-cycle `reti` strobe ends the innermost service routine and reopens arbitration for that level. Saving the program counter and executing instructions are left to the core.

Source index k, used by the enable and priority fields, is: 0 external request A, 1 timer 0, 2 external request B, 3 timer 1, 4 serial.

Top module: `intc_two_level`

## Requirements
- R1: When `en_reg[7]` is 0, `irq_valid` stays 0 whatever flags and per-source enables are set.
- R2: With `en_reg[7]` at 1, source k can win only when `en_reg[k]` is 1. A disabled source never wins, even when it ranks higher in the order.
- R3: Within one level, the order is source 0 first, then 1, 2, 3, 4. The vector for source k is 0x0003 + 8*k, so the five vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R4: A source with `pri_reg[k]`=1 is high level and wins over every pending low-level source.
- R5: An `ack` while `irq_valid` is 1 marks the winner's level in service. `in_svc[1]` is the high level and `in_svc[0]` is the low level. While a low-level routine is in service, another low request waits, but a high request is presented.
- R6: While the high level is in service, `irq_valid` is 0.
- R7: A `reti` pulse clears the high in-service bit if it is set, and otherwise clears the low bit. This restores arbitration for that level.
- R8: When `edge_mode[j]`=1, external flag j (bit 0 for pin 0, bit 2 for pin 1 of `pend_flags`) is set by a high-to-low transition of `ext_pin_n[j]` and cleared when that source is acknowledged. When `edge_mode[j]`=0, the flag is simply the inverse of the pin level.
- R9: A one-cycle `tmr_ovf[t]` pulse sets timer flag t (`pend_flags` bit 1 or bit 3). The flag stays set until that source is acknowledged, and the acknowledge clears it.
- R10: The serial flag (`pend_flags[4]`) follows `ser_req`, and an acknowledge does not clear it.
- R11: After reset, `irq_valid`, `pend_flags` and `in_svc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_n | input | 2 | External request pins, active low |
| edge_mode | input | 2 | Per pin: 1 means falling-edge latched, 0 means level |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_req | input | 1 | Combined serial request level |
| en_reg | input | 8 | Bit 7 is the master enable; bits 4:0 are the per-source enables |
| pri_reg | input | 5 | Per-source high-priority select |
| ack | input | 1 | Core takes the presented request |
| reti | input | 1 | Core returns from the innermost service routine |
| irq_valid | output | 1 | A request is presented |
| irq_vector | output | 16 | Vector address of the presented request |
| pend_flags | output | 5 | Raw request flags by source index |
| in_svc | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The arbiter is driven with single requests and with all five sources raised in the same cycle. The single requests show that each vector maps to the right source. The simultaneous burst, drained by repeated acknowledge and return pairs, exposes any mistake in the fixed order, in flag clearing, or in the hardware leaving the serial flag alone. Enable patterns that block one source or the master bit show whether gating happens before ranking. A nested run (a low routine, then a same-level request, then a high preemption, then a high request during high service, then unwinding returns) separates the rules for same-level waiting, preemption and restore. A level-mode pin held and released shows that the flag tracks the pin rather than latching.

// File: rtl/intc_two_level.sv
module intc_two_level (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ext_pin_n,
  input  logic [1:0]  edge_mode,
  input  logic [1:0]  tmr_ovf,
  input  logic        ser_req,
  input  logic [7:0]  en_reg,
  input  logic [4:0]  pri_reg,
  input  logic        ack,
  input  logic        reti,
  output logic        irq_valid,
  output logic [15:0] irq_vector,
  output logic [4:0]  pend_flags,
  output logic [1:0]  in_svc
);

  logic [1:0] pin_q, ext_lat, tmr_f, ext_flag, fall;
  logic [4:0] req, hi_req, lo_req, cand;
  logic [2:0] sel;
  logic       hi_ok, take;

  assign fall = pin_q & ~ext_pin_n;
  assign ext_flag = (edge_mode & ext_lat) | (~edge_mode & ~ext_pin_n);
  assign pend_flags = {ser_req, tmr_f[1], ext_flag[1], tmr_f[0], ext_flag[0]};

  assign req    = pend_flags & en_reg[4:0] & {5{en_reg[7]}};
  assign hi_req = req & pri_reg;
  assign lo_req = req & ~pri_reg;
  assign hi_ok  = (|hi_req) && !in_svc[1];

  always_comb begin
    if (hi_ok)                       cand = hi_req;
    else if (in_svc == 2'b00)        cand = lo_req;
    else                             cand = 5'b0;
    sel = 3'd0;
    for (int i = 4; i >= 0; i--)
      if (cand[i]) sel = 3'(i);
  end

  assign irq_valid  = |cand;
  assign irq_vector = {10'b0, sel, 3'b011};
  assign take       = irq_valid && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 2'b11;
      ext_lat <= 2'b00;
      tmr_f   <= 2'b00;
      in_svc  <= 2'b00;
    end else begin
      pin_q <= ext_pin_n;
      for (int j = 0; j < 2; j++) begin
        if (fall[j])                             ext_lat[j] <= 1'b1;
        else if (take && sel == 3'(2*j))         ext_lat[j] <= 1'b0;
        if (tmr_ovf[j])                          tmr_f[j]   <= 1'b1;
        else if (take && sel == 3'(2*j+1))       tmr_f[j]   <= 1'b0;
      end
      in_svc <= (reti ? (in_svc[1] ? {1'b0, in_svc[0]} : 2'b00) : in_svc)
              | (take ? (hi_ok ? 2'b10 : 2'b01) : 2'b00);
    end
  end

  // R1
  glob_en_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_valid |-> en_reg[7]);
  // R6
  hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n) in_svc[1] |-> !irq_valid);
  // R5
  low_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && in_svc[0]) |-> pri_reg[sel]);
  // R3
  vec_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector[2:0] == 3'b011 && irq_vector[15:6] == 10'b0 && irq_vector[5:3] <= 3'd4));
  // R9
  tmr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel == 3'd1 && !tmr_ovf[0]) |=> !pend_flags[1]);
  // R7
  reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && in_svc[1] && !take) |=> !in_svc[1]);

endmodule

// File: tb/intc_two_level_tb.sv
`timescale 1ns/1ps
module intc_two_level_tb_top;
  logic clk = 0, rst_n = 0;
  logic [1:0] ext_pin_n = 2'b11, edge_mode = 2'b11, tmr_ovf = 0;
  logic ser_req = 0, ack = 0, reti = 0;
  logic [7:0] en_reg = 0;
  logic [4:0] pri_reg = 0;
  logic irq_valid;
  logic [15:0] irq_vector;
  logic [4:0] pend_flags;
  logic [1:0] in_svc;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  intc_two_level dut_i (.clk, .rst_n, .ext_pin_n, .edge_mode, .tmr_ovf, .ser_req,
    .en_reg, .pri_reg, .ack, .reti, .irq_valid, .irq_vector, .pend_flags, .in_svc);

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ext_pin_n = 2'b11; edge_mode = 2'b11; tmr_ovf = 0; ser_req = 0;
    en_reg = 0; pri_reg = 0; ack = 0; reti = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1; @(negedge clk); ack = 0;
  endtask

  task automatic do_reti();
    reti = 1; @(negedge clk); reti = 0;
  endtask

  task automatic pulse_tmr(input int t);
    tmr_ovf[t] = 1; @(negedge clk); tmr_ovf[t] = 0;
  endtask

  task automatic fall_pin(input int j);
    ext_pin_n[j] = 0; @(negedge clk); ext_pin_n[j] = 1; @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(irq_valid, 0, "R11 valid");
    chk(pend_flags, 0, "R11 flags");
    chk(in_svc, 0, "R11 in_svc");
  endtask

  task automatic t_global();
    do_reset();
    en_reg = 8'h1F;
    pulse_tmr(0);
    chk(pend_flags, 16'h02, "R9 timer flag set");
    chk(irq_valid, 0, "R1 master off");
    en_reg = 8'h9F; #1;
    chk(irq_valid, 1, "R1 master on");
    chk(irq_vector, 16'h000B, "R1 vector");
  endtask

  task automatic t_enable();
    do_reset();
    en_reg = 8'h9D;
    tmr_ovf = 2'b11; @(negedge clk); tmr_ovf = 0;
    chk(irq_vector, 16'h001B, "R2 disabled source skipped");
    chk(irq_valid, 1, "R2 valid");
  endtask

  task automatic t_order();
    logic [15:0] exp_v;
    do_reset();
    en_reg = 8'h9F;
    ext_pin_n = 2'b00; tmr_ovf = 2'b11; ser_req = 1;
    @(negedge clk); tmr_ovf = 0;
    for (int k = 0; k < 5; k++) begin
      exp_v = 16'(3 + 8*k);
      chk(irq_vector, exp_v, "R3 order vector");
      do_ack();
      chk(irq_valid, 0, "R5 low waits during low service");
      chk(in_svc, 2'b01, "R5 low level recorded");
      do_reti();
      chk(in_svc, 2'b00, "R7 low restored");
    end
    chk(pend_flags, 16'h10, "R8 R9 R10 only serial flag remains");
    chk(irq_vector, 16'h0023, "R10 serial still requesting");
    ext_pin_n = 2'b11; ser_req = 0;
  endtask

  task automatic t_priority();
    do_reset();
    en_reg = 8'h9F; pri_reg = 5'b10000;
    ser_req = 1;
    fall_pin(0);
    chk(irq_vector, 16'h0023, "R4 high serial beats ext0");
  endtask

  task automatic t_nesting();
    do_reset();
    en_reg = 8'h9F; pri_reg = 5'b00010;
    fall_pin(0);
    chk(irq_vector, 16'h0003, "R5 ext0 vector");
    do_ack();
    chk(in_svc, 2'b01, "R5 low in service");
    fall_pin(1);
    chk(irq_valid, 0, "R5 same level waits");
    pulse_tmr(0);
    chk(irq_valid, 1, "R5 high preempts");
    chk(irq_vector, 16'h000B, "R5 preempt vector");
    do_ack();
    chk(in_svc, 2'b11, "R5 both levels in service");
    pulse_tmr(0);
    chk(irq_valid, 0, "R6 high blocks high");
    do_reti();
    chk(in_svc, 2'b01, "R7 high cleared first");
    chk(irq_vector, 16'h000B, "R7 high rearbitrated");
    do_ack(); do_reti(); do_reti();
    chk(in_svc, 2'b00, "R7 all cleared");
    chk(irq_vector, 16'h0013, "R7 ext1 finally served");
  endtask

  task automatic t_level();
    do_reset();
    edge_mode = 2'b00; en_reg = 8'h9F;
    ext_pin_n[0] = 0; #1;
    chk(pend_flags[0], 1, "R8 level flag follows pin");
    @(negedge clk);
    do_ack();
    chk(pend_flags[0], 1, "R8 level not cleared by ack");
    do_reti();
    ext_pin_n[0] = 1; #1;
    chk(pend_flags[0], 0, "R8 level flag drops with pin");
    chk(irq_valid, 0, "R8 no request after release");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_global();
    t_enable();
    t_order();
    t_priority();
    t_nesting();
    t_level();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule